// File: doc/BRIEF.md
# NOR Flash Buffered Program Sequencer

This block drives a burst of 16-bit words into the page buffer of an external NOR flash and commits it with the buffered-program command flow. A host asserts a start pulse carrying a byte start address and a word count. The sequencer then owns the external write port. It issues the unlock handshake, the buffer-load command, the encoded word count, every data word and the confirm command, with each bus cycle held until the memory side acknowledges it.

Payload words come from a valid/ready stream. The stream is accepted only while the sequencer is in its data phase and has no bus cycle outstanding, so exactly one word is consumed per acknowledged data cycle. The requested count is checked against a configurable buffer depth before anything reaches the bus. Completion polling is left to other logic, which reacts to the done pulse.

Top module: `nor_wbuf_seq`

## Requirements
- R1: A valid request starts with two unlock cycles: data 0x00AA at byte address BASE_ADDR+0xAAA (word 0x555), then data 0x0055 at byte address BASE_ADDR+0x554 (word 0x2AA). `busy` rises the cycle after the accepted start.
- R2: The third bus cycle writes the buffer-load command 0x0025 to the request start address.
- R3: The fourth bus cycle writes count minus one, zero-extended to 16 bits, to the request start address.
- R4: Data words follow in stream order, word i going to byte address start+2*i.
- R5: The last bus cycle writes the confirm command 0x0029 to start+2*(count-1), the address of the last loaded word. A request of N words produces exactly N+5 bus cycles.
- R6: A request whose count is 0 or above MAX_WORDS raises `err` for exactly the cycle after the start, produces no bus cycle, and leaves `busy` low.
- R7: A start pulse while `busy` is high is ignored: no error, and the running sequence is unchanged.
- R8: `wr_ready` is high only in the data phase while no bus cycle is outstanding. Each accepted word becomes the next bus cycle, and exactly N words are taken per request.
- R9: `done` is a one-cycle pulse in the cycle after the confirm cycle is acknowledged, and `busy` falls in that same cycle.
- R10: Once `bus_stb` is raised, it stays high with stable `bus_addr` and `bus_wdata` until a cycle in which `bus_ack` is high.
- R11: After reset, `busy`, `bus_stb`, `wr_ready`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request pulse |
| req_addr | input | AW | Byte start address, inside the target sector |
| req_count | input | CNT_W | Number of 16-bit words |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Pulse: request count rejected |
| done | output | 1 | Pulse: confirm cycle acknowledged |
| wr_data | input | 16 | Payload word |
| wr_valid | input | 1 | Payload word present |
| wr_ready | output | 1 | Payload word taken this cycle if valid |
| bus_addr | output | AW | External write byte address |
| bus_wdata | output | 16 | External write data |
| bus_stb | output | 1 | Write cycle request |
| bus_ack | input | 1 | Write cycle acknowledge |

## Verification
Requests are swept over every legal count from one word to the buffer depth, at two start addresses. The acknowledge latency and the gaps in the data stream vary per request, so the ordering and addressing of the transcript are shown to be independent of memory and producer speed. Counts of zero, one above the depth and the field maximum separate correct rejection from an off-by-one in the limit compare. Start pulses injected mid-sequence show that a busy sequencer ignores them and does not disturb the transcript.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK_A,
    ST_UNLK_B,
    ST_LOAD,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM
  } seq_st_t;

  localparam logic [15:0] CMD_UNLK_A      = 16'h00AA;
  localparam logic [15:0] CMD_UNLK_B      = 16'h0055;
  localparam logic [15:0] CMD_BUF_LOAD    = 16'h0025;
  localparam logic [15:0] CMD_BUF_CONFIRM = 16'h0029;

  localparam logic [11:0] UNLK_A_WADDR = 12'h555;
  localparam logic [11:0] UNLK_B_WADDR = 12'h2AA;

endpackage

// File: rtl/nwb_req_check.sv
module nwb_req_check #(
  parameter int CNT_W     = 8,
  parameter int MAX_WORDS = 32
) (
  input  logic [CNT_W-1:0] count,
  output logic             ok
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(MAX_WORDS);

  always_comb begin
    ok = (count != '0) && ({1'b0, count} <= LIMIT);
  end
endmodule

// File: rtl/nwb_addr_track.sv
module nwb_addr_track #(
  parameter int AW    = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    start_addr,
  input  logic [CNT_W-1:0] start_count,
  input  logic             step,
  output logic [AW-1:0]    cur_addr,
  output logic [CNT_W-1:0] remain,
  output logic             last
);
  localparam logic [AW-1:0]    WORD_BYTES = AW'(2);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  always_comb begin
    last = (remain == ONE);
  end

  // The address stops on the final word so the confirm can reuse it.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
      remain   <= start_count;
    end else if (step) begin
      remain <= remain - ONE;
      if (!last) cur_addr <= cur_addr + WORD_BYTES;
    end
  end

  AST_STEP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    step |-> remain != '0); // R4
endmodule

// File: rtl/nwb_bus_drive.sv
module nwb_bus_drive #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic [15:0]   issue_data,
  input  logic          retire,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  output logic          bus_stb
);
  // Issue wins over retire so that command cycles run back to back.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_stb   <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (issue) begin
      bus_stb   <= 1'b1;
      bus_addr  <= issue_addr;
      bus_wdata <= issue_data;
    end else if (retire) begin
      bus_stb <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_wbuf_seq.sv
module nor_wbuf_seq
  import nwb_pkg::*;
#(
  parameter int             AW        = 24,
  parameter int             CNT_W     = 8,
  parameter int             MAX_WORDS = 32,
  parameter logic [AW-1:0]  BASE_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_start,
  input  logic [AW-1:0]    req_addr,
  input  logic [CNT_W-1:0] req_count,
  output logic             busy,
  output logic             err,
  output logic             done,
  input  logic [15:0]      wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [AW-1:0]    bus_addr,
  output logic [15:0]      bus_wdata,
  output logic             bus_stb,
  input  logic             bus_ack
);
  localparam logic [AW-1:0]    UNLK_A_BADDR = BASE_ADDR + AW'({UNLK_A_WADDR, 1'b0});
  localparam logic [AW-1:0]    UNLK_B_BADDR = BASE_ADDR + AW'({UNLK_B_WADDR, 1'b0});
  localparam logic [CNT_W-1:0] ONE          = CNT_W'(1);
  localparam logic [CNT_W:0]   LIMIT        = (CNT_W+1)'(MAX_WORDS);

  seq_st_t          st, st_nxt;
  logic             count_ok;
  logic             accept;
  logic             issue, retire, load, step;
  logic [AW-1:0]    issue_addr;
  logic [15:0]      issue_data;
  logic             err_nxt, done_nxt;
  logic [AW-1:0]    cur_addr;
  logic [CNT_W-1:0] remain;
  logic             last;

  nwb_req_check #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)) u_check (
    .count (req_count),
    .ok    (count_ok)
  );

  nwb_addr_track #(.AW(AW), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .start_addr  (req_addr),
    .start_count (req_count),
    .step        (step),
    .cur_addr    (cur_addr),
    .remain      (remain),
    .last        (last)
  );

  nwb_bus_drive #(.AW(AW)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_addr (issue_addr),
    .issue_data (issue_data),
    .retire     (retire),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_stb    (bus_stb)
  );

  always_comb begin
    accept   = bus_stb && bus_ack;
    busy     = (st != ST_IDLE);
    wr_ready = (st == ST_DATA) && !bus_stb;
  end

  always_comb begin
    st_nxt     = st;
    issue      = 1'b0;
    issue_addr = cur_addr;
    issue_data = '0;
    retire     = accept;
    load       = 1'b0;
    step       = 1'b0;
    err_nxt    = 1'b0;
    done_nxt   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_start) begin
          if (count_ok) begin
            load       = 1'b1;
            issue      = 1'b1;
            issue_addr = UNLK_A_BADDR;
            issue_data = CMD_UNLK_A;
            st_nxt     = ST_UNLK_A;
          end else begin
            err_nxt = 1'b1;
          end
        end
      end
      ST_UNLK_A: begin
        if (accept) begin
          issue      = 1'b1;
          issue_addr = UNLK_B_BADDR;
          issue_data = CMD_UNLK_B;
          st_nxt     = ST_UNLK_B;
        end
      end
      ST_UNLK_B: begin
        if (accept) begin
          issue      = 1'b1;
          issue_data = CMD_BUF_LOAD;
          st_nxt     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (accept) begin
          issue      = 1'b1;
          issue_data = 16'(remain - ONE);
          st_nxt     = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (accept) st_nxt = ST_DATA;
      end
      ST_DATA: begin
        if (wr_valid && wr_ready) begin
          issue      = 1'b1;
          issue_data = wr_data;
        end
        if (accept) begin
          step = 1'b1;
          if (last) begin
            issue      = 1'b1;
            issue_data = CMD_BUF_CONFIRM;
            st_nxt     = ST_CONFIRM;
          end
        end
      end
      ST_CONFIRM: begin
        if (accept) begin
          done_nxt = 1'b1;
          st_nxt   = ST_IDLE;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      st   <= st_nxt;
      err  <= err_nxt;
      done <= done_nxt;
    end
  end

  AST_START_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    req_start && !busy && req_count != '0 && {1'b0, req_count} <= LIMIT
    |=> busy && bus_stb && bus_wdata == CMD_UNLK_A && bus_addr == UNLK_A_BADDR); // R1
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_start && !busy && (req_count == '0 || {1'b0, req_count} > LIMIT)
    |=> err && !busy && !bus_stb); // R6
  AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    req_start && busy |=> !err); // R7
  AST_TAKE_WORD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready |=> bus_stb && bus_wdata == $past(wr_data)); // R8
  AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_stb && !bus_ack |=> bus_stb && $stable(bus_addr) && $stable(bus_wdata)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !bus_stb && !err); // R9
endmodule

// File: tb/test_nor_wbuf_seq.sv
module test_nor_wbuf_seq;
  localparam int            AW    = 24;
  localparam int            CNT_W = 8;
  localparam int            MAXW  = 8;
  localparam logic [AW-1:0] BASE  = 24'h100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_start = 1'b0;
  logic [AW-1:0]    req_addr = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic             busy, err, done, wr_ready, bus_stb;
  logic [15:0]      wr_data = '0;
  logic             wr_valid = 1'b0;
  logic [AW-1:0]    bus_addr;
  logic [15:0]      bus_wdata;
  logic             bus_ack = 1'b0;

  always #10 clk = ~clk;

  nor_wbuf_seq #(.AW(AW), .CNT_W(CNT_W), .MAX_WORDS(MAXW), .BASE_ADDR(BASE)) i_nor_wbuf_seq (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr), .req_count(req_count),
    .busy(busy), .err(err), .done(done), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stb(bus_stb),
    .bus_ack(bus_ack)
  );

  int nvec = 0, nfail = 0;
  logic [AW-1:0] tr_addr [0:63];
  logic [15:0]   tr_data [0:63];
  int tr_n = 0, cyc = 0, ack_wait = 0, lat_sel = 0, stall_sel = 0;
  int word_idx = 0, cur_count = 0, req_id = 0;
  int done_cnt = 0, done_cyc = -1, last_ack_cyc = -2, err_seen = 0, rdy_bad = 0;
  logic rdy_q = 1'b0;

  function automatic logic [15:0] word_val(input int r, input int i);
    return 16'((r * 16'h1357) ^ (i * 16'h0A0B) ^ 16'h4000);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory-side responder, stream producer and monitors, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (done) begin done_cnt++; done_cyc = cyc; end
      if (err) err_seen++;
      if (wr_ready && (bus_stb || tr_n < 4 || tr_n >= 4 + cur_count)) rdy_bad++; // R8
      if (bus_ack) begin
        bus_ack = 1'b0;
        last_ack_cyc = cyc;
        ack_wait = 0;
      end else if (bus_stb) begin
        if (ack_wait >= (tr_n + lat_sel) % 3) begin
          if (tr_n < 64) begin
            tr_addr[tr_n] = bus_addr;
            tr_data[tr_n] = bus_wdata;
          end
          tr_n++;
          bus_ack = 1'b1;
        end else ack_wait++;
      end
      if (wr_valid && rdy_q) word_idx++;
      rdy_q    = wr_ready;
      wr_valid = (word_idx < cur_count) && (((cyc + stall_sel) % 4) != 0);
      wr_data  = word_val(req_id, word_idx);
    end
  end

  task automatic run_req(input logic [AW-1:0] a, input int cnt, input int lat,
                         input int stall, input bit inject);
    bit valid;
    int guard;
    valid = (cnt >= 1 && cnt <= MAXW);
    @(negedge clk);
    tr_n = 0; word_idx = 0; done_cnt = 0; err_seen = 0; rdy_bad = 0;
    cur_count = valid ? cnt : 0;
    req_id++; lat_sel = lat; stall_sel = stall;
    req_addr = a; req_count = CNT_W'(cnt); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (!valid) begin
      chk(err == 1'b1, "R6 err pulse", err, 1);
      chk(busy == 1'b0, "R6 busy", busy, 0);
      repeat (4) @(negedge clk);
      chk(err_seen == 1, "R6 err count", err_seen, 1);
      chk(tr_n == 0, "R6 bus cycles", tr_n, 0);
      chk(done_cnt == 0, "R6 done", done_cnt, 0);
    end else begin
      chk(busy == 1'b1, "R1 busy", busy, 1);
      if (inject) begin
        repeat (3) @(negedge clk);
        req_addr = a + 24'h400; req_count = CNT_W'(1); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
      end
      guard = 0;
      while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
      repeat (3) @(negedge clk);
      chk(tr_n == cnt + 5, "R5 cycle count", tr_n, cnt + 5);
      if (tr_n == cnt + 5) begin
        chk(tr_addr[0] == BASE + 24'hAAA && tr_data[0] == 16'h00AA, "R1 unlock A", tr_data[0], 16'h00AA);
        chk(tr_addr[1] == BASE + 24'h554 && tr_data[1] == 16'h0055, "R1 unlock B", tr_data[1], 16'h0055);
        chk(tr_addr[2] == a && tr_data[2] == 16'h0025, "R2 load cmd", tr_addr[2], a);
        chk(tr_addr[3] == a && tr_data[3] == 16'(cnt - 1), "R3 count-1", tr_data[3], cnt - 1);
        for (int i = 0; i < cnt; i++) begin
          chk(tr_addr[4+i] == a + AW'(2*i) && tr_data[4+i] == word_val(req_id, i),
              "R4 data word", tr_data[4+i], word_val(req_id, i));
        end
        chk(tr_addr[cnt+4] == a + AW'(2*(cnt-1)) && tr_data[cnt+4] == 16'h0029,
            "R5 confirm", tr_addr[cnt+4], a + AW'(2*(cnt-1)));
      end
      chk(done_cnt == 1, "R9 done count", done_cnt, 1);
      chk(done_cyc == last_ack_cyc, "R9 done timing", done_cyc, last_ack_cyc);
      chk(busy == 1'b0, "R9 busy low", busy, 0);
      chk(word_idx == cnt, "R8 words taken", word_idx, cnt);
      chk(rdy_bad == 0, "R8 ready window", rdy_bad, 0);
      chk(err_seen == 0, "R7 no err", err_seen, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && bus_stb == 0 && wr_ready == 0 && done == 0 && err == 0,
        "R11 reset state", {busy, bus_stb, wr_ready, done, err}, 0);
    for (int c = 1; c <= MAXW; c++) begin
      run_req(BASE + 24'h000200, c, c % 3, c % 4, 1'b0);
      run_req(BASE + 24'h07FFE0, c, (c + 1) % 3, (c + 2) % 4, c % 3 == 0); // R7 on some
    end
    run_req(BASE + 24'h000040, 0, 0, 0, 1'b0);
    run_req(BASE + 24'h000040, MAXW + 1, 0, 0, 1'b0);
    run_req(BASE + 24'h000040, 255, 0, 0, 1'b0);
    run_req(BASE + 24'h001000, MAXW, 2, 1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #3000000;
    nvec++; nfail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule